// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Detector

The detector watches a vector of input pins and raises one pending flag per group of eight pins when an enabled pin in that group changes level. Each pin passes through three registers in sequence: a capture stage, a synchroniser stage and a history stage. A change is found by comparing the synchronised value with the history value, so rising and falling transitions count the same way. The per-pin change bits are gated by a mask and ORed within their group. The result sets a sticky group flag, which stays set until software clears it or the interrupt controller acknowledges it.

The pins are sensed whatever drives them, including the chip's own output drivers. Software can therefore raise an interrupt by writing a pin. When there is no clock, a combinational wake output reports any masked pin whose level differs from its captured value. Vector dispatch and sleep control sit outside the block.

Top module: `pcd_top`

## Requirements
- R1: Pin i belongs to group i/8. Pins 7..0 drive group 0, pins 15..8 drive group 1, pins 23..16 drive group 2 and pins 30..24 drive group 3. Bit g of `flag_o` and `irq_o` belongs to group g.
- R2: A pin whose `mask_i` bit is 0 never sets its group flag and never asserts `wake_o`.
- R3: A rising transition and a falling transition of an enabled pin each set the group flag.
- R4: Latency. If a pin changes between two rising clock edges, its group flag reads 0 after the second edge that follows the change and reads 1 after the third.
- R5: A set flag stays 1 until the cycle in which its `clr_i` bit or its `ack_i` bit is 1. It reads 0 after that edge.
- R6: If a group's flag is set and cleared in the same cycle, the set wins and the flag stays 1.
- R7: `irq_o[g]` equals `flag_o[g] AND en_i[g]`. A disabled group still records its flag, and the request appears as soon as the group is enabled.
- R8: `wake_o` goes to 1 without any clock edge when a masked-in pin differs from its captured value. It returns to 0 after the next rising edge.
- R9: Reset clears all flags. The pipeline registers load the present pin levels, so non-zero pins at reset cause no flag after reset is released.
- R10: Changes on pins in different groups in the same cycle set every affected group flag together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NUM_PINS | Raw pin levels |
| mask_i | input | NUM_PINS | Per-pin contribution mask, 1 = counts |
| en_i | input | NUM_GROUPS | Per-group request enable |
| clr_i | input | NUM_GROUPS | Per-group flag clear, active high |
| ack_i | input | NUM_GROUPS | Per-group interrupt acknowledge pulse |
| flag_o | output | NUM_GROUPS | Sticky per-group pending flags |
| irq_o | output | NUM_GROUPS | Per-group interrupt requests |
| wake_o | output | 1 | Combinational any-change wake indication |

## Verification
Some rules are checked by assertions on every clock cycle:
- the flag update rules: set wins, clear works, the flag holds otherwise;
- a flag never rises without a masked group hit in the cycle before;
- the capture stage follows the pins one cycle late.

Other behaviour can only be shown by the bench scenarios:
- the exact three-edge latency;
- the mapping of pins to groups, including the short last group;
- both edge directions;
- the wake output rising with no clock edge;
- masked pins being ignored;
- enable gating of a recorded flag;
- a clean start from non-zero pins.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int GRP_W = 8;

  function automatic int num_groups(input int pins, input int width);
    return (pins + width - 1) / width;
  endfunction
endpackage

// File: rtl/pcd_pin_pipe.sv
module pcd_pin_pipe #(
  parameter int NUM_PINS = 31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] mask_i,
  output logic [NUM_PINS-1:0] toggle_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] lat_q, sync_q, prev_q;

  // reset loads live pin levels so no change is seen on release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= pin_i;
      sync_q <= pin_i;
      prev_q <= pin_i;
    end else begin
      lat_q  <= pin_i;
      sync_q <= lat_q;
      prev_q <= sync_q;
    end
  end

  assign toggle_o = (sync_q ^ prev_q) & mask_i;
  // clockless path: raw pin against captured level
  assign wake_o   = |((pin_i ^ lat_q) & mask_i);

  p_lat_tracks_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q == $past(pin_i));
endmodule

// File: rtl/pcd_group_flag.sv
module pcd_group_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic ack_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b0;
    else if (hit_i)             flag_q <= 1'b1;
    else if (clr_i || ack_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_q);
  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && (clr_i || ack_i)) |=> !flag_q);
  p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !clr_i && !ack_i && flag_q) |=> flag_q);
  p_no_spurious_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit_i));
endmodule

// File: rtl/pcd_top.sv
module pcd_top #(
  parameter  int NUM_PINS   = 31,
  parameter  int GROUP_W    = pcd_pkg::GRP_W,
  localparam int NUM_GROUPS = pcd_pkg::num_groups(NUM_PINS, GROUP_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [NUM_PINS-1:0]   mask_i,
  input  logic [NUM_GROUPS-1:0] en_i,
  input  logic [NUM_GROUPS-1:0] clr_i,
  input  logic [NUM_GROUPS-1:0] ack_i,
  output logic [NUM_GROUPS-1:0] flag_o,
  output logic [NUM_GROUPS-1:0] irq_o,
  output logic                  wake_o
);
  localparam int PAD_W = NUM_GROUPS * GROUP_W;

  logic [NUM_PINS-1:0]   toggle;
  logic [PAD_W-1:0]      toggle_pad;
  logic [NUM_GROUPS-1:0] grp_hit;

  pcd_pin_pipe #(.NUM_PINS(NUM_PINS)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .mask_i  (mask_i),
    .toggle_o(toggle),
    .wake_o  (wake_o)
  );

  // short last group is zero-filled
  always_comb begin
    toggle_pad                = '0;
    toggle_pad[NUM_PINS-1:0]  = toggle;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = |toggle_pad[g*GROUP_W +: GROUP_W];

    pcd_group_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .hit_i (grp_hit[g]),
      .clr_i (clr_i[g]),
      .ack_i (ack_i[g]),
      .en_i  (en_i[g]),
      .flag_o(flag_o[g]),
      .irq_o (irq_o[g])
    );
  end
endmodule

// File: tb/pcd_top_tb.sv
`timescale 1ns/1ps
module pcd_top_tb;
  localparam int NP = 31;
  localparam int NG = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pins = 31'h2A5A_C3F0;
  logic [NP-1:0] mask = '1;
  logic [NG-1:0] en = '1, clr = '0, ack = '0;
  logic [NG-1:0] flag, irq;
  logic wake;

  always #4 clk = ~clk;

  pcd_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .mask_i(mask),
    .en_i(en), .clr_i(clr), .ack_i(ack),
    .flag_o(flag), .irq_o(irq), .wake_o(wake)
  );

  typedef struct {
    int            cyc;
    logic [NG-1:0] f;
    logic [NG-1:0] i;
    string         tag;
  } exp_t;

  exp_t q[$];
  int cyc_cnt = 0;
  int nvec = 0;
  int nfail = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // monitor: compares every item due in this cycle
  initial forever begin
    @(posedge clk);
    #1;
    for (int k = 0; k < q.size(); ) begin
      if (q[k].cyc == cyc_cnt) begin
        nvec++;
        if (flag !== q[k].f || irq !== q[k].i) begin
          nfail++;
          $display("FAIL %s: flag=%b irq=%b expected flag=%b irq=%b",
                   q[k].tag, flag, irq, q[k].f, q[k].i);
        end
        q.delete(k);
      end else k++;
    end
  end

  task automatic expect_at(string tag, int d, logic [NG-1:0] f, logic [NG-1:0] i);
    exp_t e;
    e.cyc = cyc_cnt + d; e.f = f; e.i = i; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic go(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_wake(string tag, logic e);
    nvec++;
    if (wake !== e) begin
      nfail++;
      $display("FAIL %s: wake=%b expected %b", tag, wake, e);
    end
  endtask

  // flip one pin at a negedge, expect flag 0 after 2 edges and set after 3
  task automatic hit(int p, string tag, logic [NG-1:0] after);
    pins[p] = ~pins[p];
    expect_at(tag, 2, '0, '0);
    expect_at(tag, 3, after, after & en);
    go(4);
  endtask

  task automatic clear_all(string tag);
    clr = '1;
    go(1);
    clr = '0;
    expect_at(tag, 1, '0, '0);
    go(2);
  endtask

  initial begin
    #(8 * 50000);
    nfail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    go(1);
    expect_at("R9 in reset", 1, '0, '0);
    go(2);
    rst_n = 1'b1;
    expect_at("R9 after release", 1, '0, '0);
    expect_at("R9 after release", 4, '0, '0);
    go(5);

    // R4, R3 rising edge on pin 3 (reset value 0), group 0 (R1)
    hit(3, "R4 R3 rise pin3", 4'b0001);
    clear_all("R5 clr");
    // R3 falling edge
    hit(3, "R3 fall pin3", 4'b0001);
    clear_all("R5 clr");
    // R1 mapping
    hit(12, "R1 pin12 grp1", 4'b0010);
    clear_all("R1 clr");
    hit(16, "R1 pin16 grp2", 4'b0100);
    clear_all("R1 clr");
    hit(30, "R1 pin30 grp3", 4'b1000);
    clear_all("R1 clr");
    hit(7, "R1 pin7 grp0", 4'b0001);
    clear_all("R1 clr");

    // R10 two groups at once
    pins[8] = ~pins[8];
    hit(25, "R10 pins 8 and 25", 4'b1010);
    clear_all("R10 clr");

    // R2 masked pin: no flag, no wake
    mask[9] = 1'b0;
    pins[9] = ~pins[9];
    #1 chk_wake("R2 masked wake", 1'b0);
    expect_at("R2 masked flag", 3, '0, '0);
    expect_at("R2 masked flag", 5, '0, '0);
    go(6);
    mask[9] = 1'b1;
    go(1);

    // R8 wake without clock edge
    pins[20] = ~pins[20];
    #1 chk_wake("R8 wake high", 1'b1);
    expect_at("R8 flag after wake", 3, 4'b0100, 4'b0100);
    @(posedge clk);
    #1 chk_wake("R8 wake low", 1'b0);
    go(4);
    clear_all("R8 clr");

    // R5 sticky then ack
    hit(0, "R5 set", 4'b0001);
    go(10);
    expect_at("R5 sticky", 1, 4'b0001, 4'b0001);
    go(2);
    ack[0] = 1'b1;
    go(1);
    ack[0] = 1'b0;
    expect_at("R5 ack clears", 1, '0, '0);
    go(2);

    // R6 set wins over clear
    clr[1] = 1'b1;
    pins[10] = ~pins[10];
    expect_at("R6 before set", 2, '0, '0);
    expect_at("R6 set wins", 3, 4'b0010, 4'b0010);
    go(3);
    expect_at("R6 clear after", 1, '0, '0);
    go(1);
    clr[1] = 1'b0;
    go(2);

    // R7 disabled group records flag
    en[2] = 1'b0;
    hit(17, "R7 disabled", 4'b0100);
    en[2] = 1'b1;
    expect_at("R7 enable shows irq", 1, 4'b0100, 4'b0100);
    go(2);
    clear_all("R7 clr");

    go(4);
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule